// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block places a small 8-bit microcontroller core into one of two low-power modes and brings it back out. Software writes a two-bit mode register. Once the instruction that did the write has retired, the controller gates the CPU clock (light sleep), or it gates the CPU clock, the peripheral clock and the main oscillator together (deep sleep).

Light sleep ends when an enabled interrupt is pending. The controller then clears the light-sleep bit, ungates the CPU and pulses a wake strobe, so the core services the interrupt and goes on from the instruction after the write. Deep sleep ignores interrupts. It ends only through a reset: external, watchdog, or the internal missing-clock detector. Any reset clears the register and asks the core to restart from the reset vector.

The missing-clock detector runs on the free-running reference clock that drives this block, so it keeps working while the oscillator is stopped. It watches a per-cycle oscillator activity strobe and fires after a parameterised number of cycles without one.

Top module: `pmc_power_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the running state after that edge. In that state `cpu_clk_en`=1, `periph_clk_en`=1, `osc_stop`=0, `mode_bits`=00, `restart_req`=0 and `wake_event`=0. This holds even if the block was sleeping.
- R2: `mode_bits[0]` selects light sleep and `mode_bits[1]` selects deep sleep. A `mode_wr` with data `mode_wdata` is stored, and shows on `mode_bits` one cycle later, only while the block is running. A write made while sleeping is ignored.
- R3: Sleep is entered at the first cycle with `instr_done`=1 that falls at or after the write cycle, while a mode bit is set. The clock outputs change one cycle after that cycle. Without `instr_done` the block stays running.
- R4: In light sleep, `cpu_clk_en`=0, `periph_clk_en`=1 and `osc_stop`=0.
- R5: In deep sleep, `cpu_clk_en`=0, `periph_clk_en`=0 and `osc_stop`=1.
- R6: When both mode bits are set at entry, deep sleep is chosen.
- R7: In light sleep, `irq_pending`=1 returns the block to running one cycle later and clears `mode_bits[0]`. `wake_event` is high for exactly that one cycle, and `restart_req` stays 0.
- R8: In deep sleep, `irq_pending` has no effect. In the running state it changes nothing either.
- R9: `ext_rst_req` or `wdt_rst_req` in any state returns the block to running with `mode_bits`=00. `restart_req` is high for one cycle after the request cycle.
- R10: With `mcd_en`=1, a reset fires once `osc_tick` has been absent for MCD_TIMEOUT cycles in a row. `restart_req` appears exactly MCD_TIMEOUT cycles after the last cycle that had a tick, and the block returns to running with `mode_bits`=00.
- R11: The detector never fires while `mcd_en`=0 or while `osc_tick` keeps arriving. Deep sleep with the detector disabled lasts until an external reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 2 | Write data: bit 0 light sleep, bit 1 deep sleep |
| instr_done | input | 1 | Current instruction has retired |
| irq_pending | input | 1 | An enabled interrupt is pending |
| ext_rst_req | input | 1 | External reset request |
| wdt_rst_req | input | 1 | Watchdog reset request |
| mcd_en | input | 1 | Missing-clock detector enable |
| osc_tick | input | 1 | Main oscillator activity strobe, one per live cycle |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_stop | output | 1 | Stop the main oscillator |
| mode_bits | output | 2 | Current mode register contents |
| restart_req | output | 1 | One-cycle request to restart at the reset vector |
| wake_event | output | 1 | One-cycle pulse on an interrupt wake |

## Verification
Every registered output (clock gates, `osc_stop`, `mode_bits`, `restart_req`, `wake_event`) responds one cycle after the input cycle that causes it. The bench therefore drives each stimulus on a falling edge, lets one rising edge pass, and compares on the next falling edge. The missing-clock reset is the only delayed result: it is due MCD_TIMEOUT cycles after the last oscillator tick. The bench counts cycles from the deep-sleep entry edge and requires the first `restart_req` on exactly that count.

// File: rtl/pmc_pkg.sv
// Shared types and field positions for the power mode controller.
package pmc_pkg;
    localparam int MODE_W   = 2;
    localparam int IDLE_BIT = 0;   // light-sleep select
    localparam int STOP_BIT = 1;   // deep-sleep select (wins over light sleep)

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_STOP = 2'd2
    } pm_state_e;
endpackage

// File: rtl/pmc_mode_reg.sv
// Mode register. Holds the two sleep-select bits.
// Assumes: wr_en is already qualified with "core running"; any_rst and rst_n clear it.
module pmc_mode_reg
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_rst,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              clr_idle,
    output logic [MODE_W-1:0] bits_q,
    output logic [MODE_W-1:0] bits_view
);
    // Store writes, clear on any reset, drop the light-sleep bit on interrupt wake.
    always_ff @(posedge clk) begin
        if (!rst_n || any_rst) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q <= wr_data;
        end else if (clr_idle) begin
            bits_q[IDLE_BIT] <= 1'b0;
        end
    end

    // Value seen by entry logic: a write retiring in the same cycle counts.
    assign bits_view = wr_en ? wr_data : bits_q;

    // R9
    rst_clears_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |=> (bits_q == '0));

    // R7
    wake_clears_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_idle && !any_rst) |=> !bits_q[IDLE_BIT]);
endmodule

// File: rtl/pmc_mcd.sv
// Missing-clock detector. Counts reference cycles with no oscillator tick.
// Assumes: TIMEOUT >= 2; the reference clock keeps running while the oscillator is stopped.
module pmc_mcd #(
    parameter int TIMEOUT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mcd_en,
    input  logic osc_tick,
    output logic mcd_fire
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    assign mcd_fire = mcd_en && !osc_tick && (cnt_q == LAST);

    // Count silent cycles; restart on a tick, when disabled, or after firing.
    always_ff @(posedge clk) begin
        if (!rst_n || !mcd_en || osc_tick || mcd_fire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R11
    tick_blocks_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_tick |=> !mcd_fire);
endmodule

// File: rtl/pmc_fsm.sv
// Run / light-sleep / deep-sleep sequencer with restart and wake pulses.
// Assumes: bits_view already reflects a write retiring this cycle.
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] bits_view,
    input  logic              instr_done,
    input  logic              irq_pending,
    input  logic              any_rst,
    output pm_state_e         state_q,
    output logic              clr_idle,
    output logic              restart_q,
    output logic              wake_q
);
    pm_state_e state_d;

    assign clr_idle = (state_q == PM_IDLE) && irq_pending && !any_rst;

    // Next-state choice: resets first, deep sleep over light sleep.
    always_comb begin
        state_d = state_q;
        if (any_rst) begin
            state_d = PM_RUN;
        end else begin
            unique case (state_q)
                PM_RUN: begin
                    if (instr_done && bits_view[STOP_BIT])      state_d = PM_STOP;
                    else if (instr_done && bits_view[IDLE_BIT]) state_d = PM_IDLE;
                end
                PM_IDLE: if (irq_pending) state_d = PM_RUN;
                PM_STOP: state_d = PM_STOP;
                default: state_d = PM_RUN;
            endcase
        end
    end

    // State and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PM_RUN;
            restart_q <= 1'b0;
            wake_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            restart_q <= any_rst;
            wake_q    <= clr_idle;
        end
    end

    // R3
    entry_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && !instr_done) |=> (state_q == PM_RUN));

    // R8
    stop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_STOP && !any_rst) |=> (state_q == PM_STOP));

    // R7
    wake_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> ($past(state_q) == PM_IDLE && state_q == PM_RUN));

    // R9
    restart_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> (state_q == PM_RUN && !wake_q));
endmodule

// File: rtl/pmc_power_ctrl.sv
// Top of the power mode controller: mode register, sequencer, missing-clock detector.
// Assumes: clk is the always-on reference clock; osc_tick marks live oscillator cycles.
module pmc_power_ctrl
    import pmc_pkg::*;
#(
    parameter int MCD_TIMEOUT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              instr_done,
    input  logic              irq_pending,
    input  logic              ext_rst_req,
    input  logic              wdt_rst_req,
    input  logic              mcd_en,
    input  logic              osc_tick,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              osc_stop,
    output logic [MODE_W-1:0] mode_bits,
    output logic              restart_req,
    output logic              wake_event
);
    pm_state_e         state_q;
    logic [MODE_W-1:0] bits_view;
    logic              clr_idle;
    logic              mcd_fire;
    logic              any_rst;
    logic              wr_en;

    assign any_rst = ext_rst_req || wdt_rst_req || mcd_fire;
    assign wr_en   = mode_wr && (state_q == PM_RUN);

    pmc_mode_reg u_mode_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_rst  (any_rst),
        .wr_en    (wr_en),
        .wr_data  (mode_wdata),
        .clr_idle (clr_idle),
        .bits_q   (mode_bits),
        .bits_view(bits_view)
    );

    pmc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bits_view  (bits_view),
        .instr_done (instr_done),
        .irq_pending(irq_pending),
        .any_rst    (any_rst),
        .state_q    (state_q),
        .clr_idle   (clr_idle),
        .restart_q  (restart_req),
        .wake_q     (wake_event)
    );

    pmc_mcd #(.TIMEOUT(MCD_TIMEOUT)) u_mcd (
        .clk     (clk),
        .rst_n   (rst_n),
        .mcd_en  (mcd_en),
        .osc_tick(osc_tick),
        .mcd_fire(mcd_fire)
    );

    // Clock gates decoded from the registered state.
    assign cpu_clk_en    = (state_q == PM_RUN);
    assign periph_clk_en = (state_q != PM_STOP);
    assign osc_stop      = (state_q == PM_STOP);

    // R5
    stop_gates_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |-> (!cpu_clk_en && !periph_clk_en && mode_bits[STOP_BIT]));

    // R4
    idle_keeps_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && !osc_stop) |-> (periph_clk_en && mode_bits[IDLE_BIT]));
endmodule

// File: tb/test_pmc_power_ctrl.sv
module test_pmc_power_ctrl;
    localparam int T = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic       instr_done = 1'b0;
    logic       irq_pending = 1'b0;
    logic       ext_rst_req = 1'b0;
    logic       wdt_rst_req = 1'b0;
    logic       mcd_en = 1'b0;
    logic       osc_tick;
    logic       cpu_clk_en, periph_clk_en, osc_stop, restart_req, wake_event;
    logic [1:0] mode_bits;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Oscillator model: ticks every cycle unless the block stops it.
    assign osc_tick = ~osc_stop;

    pmc_power_ctrl #(.MCD_TIMEOUT(T)) i_pmc_power_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .instr_done(instr_done), .irq_pending(irq_pending),
        .ext_rst_req(ext_rst_req), .wdt_rst_req(wdt_rst_req), .mcd_en(mcd_en),
        .osc_tick(osc_tick), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .osc_stop(osc_stop), .mode_bits(mode_bits), .restart_req(restart_req),
        .wake_event(wake_event)
    );

    // Stimulus {wr, wd1, wd0, done, irq, ext, wdt} | expected {cpu, per, osc, b1, b0, restart, wake}
    localparam logic [13:0] VEC [16] = '{
        14'b0000000_1100000,  // R1 quiet running
        14'b1010000_1100100,  // R2 write light sleep, no retire yet
        14'b0001000_0100100,  // R3 R4 retire -> light sleep
        14'b0000000_0100100,  // R4 stays asleep
        14'b0000100_1100001,  // R7 interrupt wake
        14'b0000000_1100000,  // R7 pulse is one cycle
        14'b1101000_0011000,  // R3 R5 write+retire deep sleep
        14'b0000100_0011000,  // R8 interrupt ignored
        14'b0000010_1100010,  // R9 external reset
        14'b0000000_1100000,  // R9 pulse is one cycle
        14'b1111000_0011100,  // R6 both bits -> deep sleep
        14'b0000001_1100010,  // R9 watchdog ends deep sleep
        14'b1011000_0100100,  // R4 light sleep again
        14'b0000001_1100010,  // R9 watchdog ends light sleep
        14'b1001000_1100000,  // R2 writing zero keeps running
        14'b0000100_1100000   // R8 interrupt while running
    };

    function automatic logic [6:0] outs();
        return {cpu_clk_en, periph_clk_en, osc_stop, mode_bits, restart_req, wake_event};
    endfunction

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] s);
        {mode_wr, mode_wdata, instr_done, irq_pending, ext_rst_req, wdt_rst_req} = s;
    endtask

    // One cycle: inputs already set on a falling edge, compare on the next falling edge.
    task automatic cyc(input logic [6:0] s);
        drive(s);
        @(negedge clk);
        drive(7'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic seen;
        repeat (3) @(negedge clk);
        // R1: state coming out of reset
        chk("R1 reset", outs(), 7'b1100000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", outs(), 7'b1100000);

        for (int i = 0; i < 16; i++) begin
            cyc(VEC[i][13:7]);
            chk($sformatf("table step %0d R2 R3 R4 R5 R6 R7 R8 R9", i), outs(), VEC[i][6:0]);
        end

        // R3: write held without retire keeps running
        cyc(7'b1010000);
        repeat (4) cyc(7'b0);
        chk("R3 no retire", outs(), 7'b1100100);
        cyc(7'b0001000);
        chk("R3 late retire", outs(), 7'b0100100);
        // R2: write during light sleep ignored
        cyc(7'b1101000);
        chk("R2 write while asleep", outs(), 7'b0100100);
        // R1: power-on reset mid-sleep, no restart pulse
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset from sleep", outs(), 7'b1100000);

        // R11: ticking oscillator never trips the detector
        mcd_en = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 3 * T; k++) begin
            @(negedge clk);
            if (restart_req) seen = 1'b1;
        end
        chk("R11 ticking clock", {6'b0, seen}, 7'b0);

        // R10: deep sleep stops ticks; restart due T cycles after entry edge
        cyc(7'b1101000);
        chk("R10 entered deep sleep", outs(), 7'b0011000);
        n = 0;
        seen = 1'b0;
        for (int k = 1; k <= 4 * T; k++) begin
            @(negedge clk);
            if (restart_req && !seen) begin
                seen = 1'b1;
                n = k;
                chk("R10 state after detector reset", outs(), 7'b1100010);
            end
        end
        chk("R10 detector delay", 7'(n), 7'(T));

        // R11: detector disabled, deep sleep holds until external reset
        mcd_en = 1'b0;
        cyc(7'b1101000);
        repeat (3 * T) @(negedge clk);
        chk("R11 disabled detector", outs(), 7'b0011000);
        cyc(7'b0000010);
        chk("R9 external reset after long sleep", outs(), 7'b1100010);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule